// File: doc/BRIEF.md
# Asynchronous Serial Port with Voting Receiver

This block is a full-duplex asynchronous serial port for use inside a larger chip. The host writes characters into a transmit queue and reads received characters, each with its own error flags, from a receive queue. A shared divider produces an oversampling tick at sixteen times the bit rate. Both the transmitter and the receiver count these ticks to mark out bit periods.

The receiver passes the line through a synchroniser. It then settles every bit, the start bit included, by majority over three samples taken in the middle of the bit. A start bit that fails this vote counts as noise, and the receiver goes back to idle. The frame format is selected at the ports: seven or eight data bits, one or two stop bits, and even, odd or no parity. The ready-to-send output and the clear-to-send input give hardware flow control.

The receiver also watches for a configurable escape character. When it arrives a set number of times in a row with no other character in between, the receiver gives a one-cycle pulse.

Top module: `serial_port_mv`

## Requirements
- R1: `cfg_len8`=1 selects 8 data bits and `cfg_len8`=0 selects 7 data bits. Data is sent least significant bit first. A received 7-bit character is returned with bit 7 cleared.
- R2: `cfg_stop2`=1 makes the transmitter send two stop bits, so an 8-bit character with no parity occupies 11 bit periods (176 ticks). The receiver checks every stop bit it expects.
- R3: `cfg_parity` selects the parity mode: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 is none. The transmitter appends the parity bit after the data bits. A received parity bit that disagrees sets `rx_perr` for that character.
- R4: Each received bit is decided by majority over the samples at oversample ticks 7, 8 and 9 of its bit period. A single-tick glitch on the line does not change the received value.
- R5: A falling edge whose start bit does not vote low is rejected. The receiver returns to idle and no character is stored.
- R6: A low value at any expected stop-bit position sets `rx_ferr` for that character. `rx_err` is high whenever the character at the head of the queue carries either error flag.
- R7: The transmit and receive queues each hold 32 entries in order. `tx_full` is high at 32 entries. A write to a full transmit queue, or a received character arriving at a full receive queue, is dropped.
- R8: `rts` goes low one cycle after the receive queue reaches 28 entries, and goes high again one cycle after the queue drops below 28.
- R9: While `cts` is low, no new character is started and `txd` stays high. A queued character starts after `cts` rises.
- R10: `esc_hit` pulses for one cycle when the character `cfg_esc` (compared over the selected length) is received error-free three times in a row. Any other character in between resets the run.
- R11: After reset `txd` and `rts` are high, `rx_empty` is high, and `tx_full` and `esc_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Clocks per oversample tick, minus one |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_parity | input | 2 | 01 even, 10 odd, otherwise none |
| cfg_esc | input | 8 | Escape character |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head received character |
| rx_perr | output | 1 | Parity error of head character |
| rx_ferr | output | 1 | Framing error of head character |
| rx_err | output | 1 | Head character carries an error |
| rx_empty | output | 1 | Receive queue empty |
| esc_hit | output | 1 | Escape run detected (pulse) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Clear to send, high = allowed |
| rts | output | 1 | Ready to send, high = room available |

## Verification
The bench runs with a divider of zero, so one bit lasts 16 clocks. A received character reaches the queue head about 12 clocks into its last stop bit: two synchroniser stages, the tick-9 vote, then one queue write. The bench therefore reads results only after the whole frame plus an idle gap. `txd` falls two clocks after a write: one clock for the queue write and one for the start decision. The bench finds that edge and samples each bit 8 clocks after its start. `rts` is registered on the queue level, so it is checked at least two clocks after the push or pop that crosses the threshold. Back-to-back frame spacing is allowed one extra clock for the idle turnaround.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int unsigned CHAR_W = 8;
   localparam int unsigned OVS    = 16;
   localparam int unsigned SUB_W  = $clog2(OVS);
   localparam int unsigned VOTE_A = 7;
   localparam int unsigned VOTE_B = 8;
   localparam int unsigned VOTE_C = 9;

   typedef enum logic [2:0] {
      LN_IDLE, LN_START, LN_DATA, LN_PAR, LN_STOP
   } ln_state_e;

   function automatic logic par_on(input logic [1:0] mode);
      return (mode == 2'b01) || (mode == 2'b10);
   endfunction

   function automatic logic par_calc(input logic [CHAR_W-1:0] d, input logic len8,
                                     input logic [1:0] mode);
      logic [CHAR_W-1:0] m;
      m = len8 ? d : {1'b0, d[CHAR_W-2:0]};
      return (^m) ^ (mode == 2'b10);
   endfunction

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned MARK  = DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             mark_hit
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   if (DEPTH != (1 << AW) || DEPTH < 2) begin : g_bad_depth
      $error("sp_fifo: DEPTH must be a power of two of at least 2");
   end
   if (MARK < 1 || MARK > DEPTH) begin : g_bad_mark
      $error("sp_fifo: MARK must lie in 1..DEPTH");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             full, do_push, do_pop;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign mark_hit = (cnt >= CW'(MARK));
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign rdata    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (cnt == CW'(DEPTH)));
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (cnt == '0));
endmodule

// File: rtl/sp_tx.sv
module sp_tx
   import sp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              len8,
   input  logic              stop2,
   input  logic [1:0]        par,
   input  logic              cts,
   input  logic              fifo_empty,
   input  logic [CHAR_W-1:0] fifo_data,
   output logic              pop,
   output logic              txd
);
   localparam int unsigned BIT_W = $clog2(CHAR_W);

   ln_state_e          st;
   logic [SUB_W-1:0]   sub;
   logic [BIT_W-1:0]   bitn, last_bit;
   logic [CHAR_W-1:0]  sh;
   logic               pbit, stopn, bit_end;

   assign bit_end  = tick && (sub == SUB_W'(OVS - 1));
   assign last_bit = len8 ? BIT_W'(CHAR_W - 1) : BIT_W'(CHAR_W - 2);
   assign pop      = (st == LN_IDLE) && !fifo_empty && cts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= LN_IDLE;
         sub   <= '0;
         bitn  <= '0;
         sh    <= '0;
         pbit  <= 1'b0;
         stopn <= 1'b0;
      end else if (st == LN_IDLE) begin
         if (pop) begin
            st   <= LN_START;
            sub  <= '0;
            sh   <= fifo_data;
            pbit <= par_calc(fifo_data, len8, par);
         end
      end else begin
         if (tick) sub <= sub + 1'b1;
         if (bit_end) begin
            case (st)
               LN_START: begin
                  st   <= LN_DATA;
                  bitn <= '0;
               end
               LN_DATA: begin
                  sh <= sh >> 1;
                  if (bitn == last_bit) begin
                     st    <= par_on(par) ? LN_PAR : LN_STOP;
                     stopn <= 1'b0;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end
               LN_PAR: begin
                  st    <= LN_STOP;
                  stopn <= 1'b0;
               end
               LN_STOP: begin
                  if (stop2 && !stopn) stopn <= 1'b1;
                  else                 st    <= LN_IDLE;
               end
               default: st <= LN_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         LN_START: txd = 1'b0;
         LN_DATA:  txd = sh[0];
         LN_PAR:   txd = pbit;
         default:  txd = 1'b1;
      endcase
   end

   // R9: with CTS low an idle transmitter stays idle
   a_r9_cts_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_IDLE && !cts) |=> (st == LN_IDLE));
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_STOP && bit_end && !(stop2 && !stopn)) |=> txd);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
   import sp_pkg::*;
#(
   parameter int unsigned ESC_REPEAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              len8,
   input  logic              stop2,
   input  logic [1:0]        par,
   input  logic [CHAR_W-1:0] esc_char,
   output logic              push,
   output logic [CHAR_W-1:0] pdata,
   output logic              perr,
   output logic              ferr,
   output logic              esc_hit
);
   localparam int unsigned BIT_W = $clog2(CHAR_W);
   localparam int unsigned EW    = $clog2(ESC_REPEAT + 1);

   ln_state_e          st;
   logic [SUB_W-1:0]   sub;
   logic [BIT_W-1:0]   bitn, last_bit;
   logic [CHAR_W-1:0]  sh, char_now;
   logic [EW-1:0]      esc_cnt;
   logic               s_a, s_b, vote, par_acc, ferr_acc, stopn, last_stop;
   logic               perr_now, ferr_now, esc_match;

   assign vote      = maj3(s_a, s_b, rxd);
   assign last_bit  = len8 ? BIT_W'(CHAR_W - 1) : BIT_W'(CHAR_W - 2);
   assign last_stop = (stopn == stop2);
   assign char_now  = len8 ? sh : {1'b0, sh[CHAR_W-1:1]};
   assign perr_now  = par_on(par) && (par_acc != (par == 2'b10));
   assign ferr_now  = ferr_acc || !vote;
   assign esc_match = len8 ? (char_now == esc_char)
                           : (char_now[CHAR_W-2:0] == esc_char[CHAR_W-2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LN_IDLE;
         sub      <= '0;
         bitn     <= '0;
         sh       <= '0;
         s_a      <= 1'b1;
         s_b      <= 1'b1;
         par_acc  <= 1'b0;
         ferr_acc <= 1'b0;
         stopn    <= 1'b0;
         push     <= 1'b0;
         pdata    <= '0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         esc_hit  <= 1'b0;
         esc_cnt  <= '0;
      end else begin
         push    <= 1'b0;
         esc_hit <= 1'b0;
         if (st == LN_IDLE) begin
            if (tick && !rxd) begin
               st       <= LN_START;
               sub      <= SUB_W'(1);
               par_acc  <= 1'b0;
               ferr_acc <= 1'b0;
            end
         end else if (tick) begin
            sub <= sub + 1'b1;
            if (sub == SUB_W'(VOTE_A)) s_a <= rxd;
            if (sub == SUB_W'(VOTE_B)) s_b <= rxd;
            if (sub == SUB_W'(VOTE_C)) begin
               case (st)
                  LN_START: if (vote) st <= LN_IDLE;
                  LN_DATA: begin
                     sh      <= {vote, sh[CHAR_W-1:1]};
                     par_acc <= par_acc ^ vote;
                  end
                  LN_PAR: par_acc <= par_acc ^ vote;
                  LN_STOP: begin
                     if (last_stop) begin
                        st    <= LN_IDLE;
                        push  <= 1'b1;
                        pdata <= char_now;
                        perr  <= perr_now;
                        ferr  <= ferr_now;
                        if (esc_match && !perr_now && !ferr_now) begin
                           if (esc_cnt == EW'(ESC_REPEAT - 1)) begin
                              esc_hit <= 1'b1;
                              esc_cnt <= '0;
                           end else begin
                              esc_cnt <= esc_cnt + 1'b1;
                           end
                        end else begin
                           esc_cnt <= '0;
                        end
                     end else if (!vote) begin
                        ferr_acc <= 1'b1;
                     end
                  end
                  default: st <= LN_IDLE;
               endcase
            end
            if (sub == SUB_W'(OVS - 1)) begin
               case (st)
                  LN_START: begin
                     st   <= LN_DATA;
                     bitn <= '0;
                  end
                  LN_DATA: begin
                     if (bitn == last_bit) begin
                        st    <= par_on(par) ? LN_PAR : LN_STOP;
                        stopn <= 1'b0;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end
                  LN_PAR: begin
                     st    <= LN_STOP;
                     stopn <= 1'b0;
                  end
                  LN_STOP: stopn <= 1'b1;
                  default: st <= LN_IDLE;
               endcase
            end
         end
      end
   end

   // R5: a start bit that votes high is dropped without a store
   a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_START && tick && sub == SUB_W'(VOTE_C) && vote) |=> (st == LN_IDLE && !push));
   a_r10_esc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      esc_hit |=> !esc_hit);
   a_r10_esc_with_char: assert property (@(posedge clk) disable iff (!rst_n)
      esc_hit |-> push);
endmodule

// File: rtl/serial_port_mv.sv
module serial_port_mv
   import sp_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 32,
   parameter int unsigned RTS_LEVEL   = 28,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ESC_REPEAT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_len8,
   input  logic              cfg_stop2,
   input  logic [1:0]        cfg_parity,
   input  logic [CHAR_W-1:0] cfg_esc,
   input  logic              tx_wr,
   input  logic [CHAR_W-1:0] tx_data,
   output logic              tx_full,
   input  logic              rx_rd,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_perr,
   output logic              rx_ferr,
   output logic              rx_err,
   output logic              rx_empty,
   output logic              esc_hit,
   input  logic              rxd,
   output logic              txd,
   input  logic              cts,
   output logic              rts
);
   localparam int unsigned RXW = CHAR_W + 2;

   if (RTS_LEVEL < 1 || RTS_LEVEL > FIFO_DEPTH) begin : g_bad_rts
      $error("serial_port_mv: RTS_LEVEL must lie in 1..FIFO_DEPTH");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("serial_port_mv: SYNC_STAGES must be at least 1");
   end
   if (ESC_REPEAT < 2) begin : g_bad_esc
      $error("serial_port_mv: ESC_REPEAT must be at least 2");
   end
   if (OVS != (1 << SUB_W)) begin : g_bad_ovs
      $error("serial_port_mv: oversample ratio must be a power of two");
   end

   // oversample tick
   logic [DIV_W-1:0] div_cnt;
   logic             tick;
   assign tick = (div_cnt == cfg_div);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_cnt <= '0;
      else if (tick) div_cnt <= '0;
      else           div_cnt <= div_cnt + 1'b1;
   end

   // receive line synchroniser
   logic rxd_s;
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rxd_s <= 1'b1;
         else        rxd_s <= rxd;
      end
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], rxd};
      end
      assign rxd_s = chain[SYNC_STAGES-1];
   end

   // transmit path
   logic              txq_empty, txq_pop;
   logic [CHAR_W-1:0] txq_data;

   sp_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH), .MARK(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data), .pop(txq_pop),
      .rdata(txq_data), .empty(txq_empty), .mark_hit(tx_full));

   sp_tx i_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .len8(cfg_len8), .stop2(cfg_stop2),
      .par(cfg_parity), .cts(cts), .fifo_empty(txq_empty), .fifo_data(txq_data),
      .pop(txq_pop), .txd(txd));

   // receive path
   logic              rx_push, rx_pe, rx_fe, rxq_high;
   logic [CHAR_W-1:0] rx_char;
   logic [RXW-1:0]    rxq_out;

   sp_rx #(.ESC_REPEAT(ESC_REPEAT)) i_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s), .len8(cfg_len8),
      .stop2(cfg_stop2), .par(cfg_parity), .esc_char(cfg_esc), .push(rx_push),
      .pdata(rx_char), .perr(rx_pe), .ferr(rx_fe), .esc_hit(esc_hit));

   sp_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH), .MARK(RTS_LEVEL)) i_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata({rx_fe, rx_pe, rx_char}),
      .pop(rx_rd), .rdata(rxq_out), .empty(rx_empty), .mark_hit(rxq_high));

   assign rx_data = rxq_out[CHAR_W-1:0];
   assign rx_perr = rxq_out[CHAR_W];
   assign rx_ferr = rxq_out[CHAR_W+1];
   assign rx_err  = !rx_empty && (rx_perr || rx_ferr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rts <= 1'b1;
      else        rts <= !rxq_high;
   end

   // R8: ready-to-send follows the receive level one cycle later
   a_r8_rts_level: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_high |=> !rts);
   a_r8_rts_room: assert property (@(posedge clk) disable iff (!rst_n)
      !rxq_high |=> rts);
endmodule

// File: tb/test_serial_port_mv.sv
module test_serial_port_mv;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [15:0] cfg_div = '0;
   logic       cfg_len8 = 1'b1, cfg_stop2 = 1'b0;
   logic [1:0] cfg_parity = 2'b00;
   logic [7:0] cfg_esc = 8'h2B;
   logic       tx_wr = 1'b0, rx_rd = 1'b0, rxd = 1'b1, cts = 1'b1;
   logic [7:0] tx_data = '0;
   logic       tx_full, rx_perr, rx_ferr, rx_err, rx_empty, esc_hit, txd, rts;
   logic [7:0] rx_data;

   int checks = 0, fails = 0, esc_seen = 0;

   always #5 clk = ~clk;

   serial_port_mv i_serial_port_mv (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len8(cfg_len8),
      .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity), .cfg_esc(cfg_esc),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
      .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_err(rx_err),
      .rx_empty(rx_empty), .esc_hit(esc_hit), .rxd(rxd), .txd(txd), .cts(cts),
      .rts(rts));

   always @(negedge clk) if (esc_hit) esc_seen++;

   // fields: [13] len8, [12] stop2, [11:10] parity, [9] bad parity, [8] bad stop, [7:0] data
   localparam logic [13:0] VEC [8] = '{
      {1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h55},
      {1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'hC3},
      {1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 8'h81},
      {1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'hF1},
      {1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 8'h2A},
      {1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 8'h0F},
      {1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'h99},
      {1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 8'h6E}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic par_en();
      return (cfg_parity == 2'b01) || (cfg_parity == 2'b10);
   endfunction

   function automatic logic [7:0] masked(input logic [7:0] d);
      return cfg_len8 ? d : {1'b0, d[6:0]};
   endfunction

   function automatic logic exp_par(input logic [7:0] d);
      return (^masked(d)) ^ (cfg_parity == 2'b10);
   endfunction

   task automatic drive_bit(input logic v, input logic gl);
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         rxd = (gl && c == 9) ? !v : v;
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic bad_par,
                             input logic bad_stop, input logic glitch);
      drive_bit(1'b0, 1'b0);
      for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) drive_bit(d[i], glitch);
      if (par_en()) drive_bit(exp_par(d) ^ bad_par, 1'b0);
      drive_bit(!bad_stop, 1'b0);
      if (cfg_stop2) drive_bit(1'b1, 1'b0);
      @(negedge clk);
      rxd = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   task automatic read_rx(output logic [7:0] d, output logic pe, output logic fe);
      @(negedge clk);
      d = rx_data; pe = rx_perr; fe = rx_ferr;
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic tx_write(input logic [7:0] d);
      @(negedge clk);
      tx_wr = 1'b1; tx_data = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic tx_capture(output logic [7:0] d, output logic pb, output logic s1,
                             output logic s2, output logic found);
      int w;
      d = '0; pb = 1'b0; s1 = 1'b0; s2 = 1'b0; found = 1'b0; w = 0;
      while (txd && w < 4000) begin
         @(negedge clk);
         w++;
      end
      if (txd) return;
      found = 1'b1;
      repeat (8) @(negedge clk);
      for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) begin
         repeat (16) @(negedge clk);
         d[i] = txd;
      end
      if (par_en()) begin
         repeat (16) @(negedge clk);
         pb = txd;
      end
      repeat (16) @(negedge clk);
      s1 = txd;
      if (cfg_stop2) begin
         repeat (16) @(negedge clk);
         s2 = txd;
      end else begin
         s2 = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic pe, fe, pb, s1, s2, found;
      int gap;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 txd", txd, 1'b1);
      chk("R11 rts", rts, 1'b1);
      chk("R11 rx_empty", rx_empty, 1'b1);
      chk("R11 tx_full", tx_full, 1'b0);
      chk("R11 esc_hit", esc_hit, 1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // table walk: R1 lengths, R2 stops, R3 parity, R6 framing
      for (int v = 0; v < 8; v++) begin
         cfg_len8   = VEC[v][13];
         cfg_stop2  = VEC[v][12];
         cfg_parity = VEC[v][11:10];
         send_frame(VEC[v][7:0], VEC[v][9], VEC[v][8], 1'b0);
         chk("R1 rx queued", rx_empty, 1'b0);
         chk("R6 rx_err", rx_err, VEC[v][9] | VEC[v][8]);
         read_rx(d, pe, fe);
         chk("R1 rx data", d, masked(VEC[v][7:0]));
         chk("R3 rx parity flag", pe, VEC[v][9]);
         chk("R6 rx framing flag", fe, VEC[v][8]);
         tx_write(VEC[v][7:0]);
         tx_capture(d, pb, s1, s2, found);
         chk("R1 tx start seen", found, 1'b1);
         chk("R1 tx data", d, masked(VEC[v][7:0]));
         if (par_en()) chk("R3 tx parity bit", pb, exp_par(VEC[v][7:0]));
         chk("R2 tx stop bits", {s1, s2}, 2'b11);
         repeat (40) @(negedge clk);
      end

      // R2 back-to-back spacing with two stop bits
      cfg_len8 = 1'b1; cfg_stop2 = 1'b1; cfg_parity = 2'b00;
      tx_write(8'hFF);
      tx_write(8'hFF);
      while (txd) @(negedge clk);
      gap = 0;
      while (!txd) begin @(negedge clk); gap++; end
      while (txd && gap < 400) begin @(negedge clk); gap++; end
      chk("R2 frame spacing 176..177", (gap >= 176 && gap <= 177), 1'b1);
      repeat (200) @(negedge clk);
      cfg_stop2 = 1'b0;

      // R4 single-tick glitches inside every data bit
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
      read_rx(d, pe, fe);
      chk("R4 voted data", d, 8'hA5);
      chk("R4 no error", {pe, fe}, 2'b00);

      // R5 short low pulse is not a start bit
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk); rxd = 1'b1;
      repeat (64) @(negedge clk);
      chk("R5 nothing stored", rx_empty, 1'b1);
      send_frame(8'h3C, 1'b0, 1'b0, 1'b0);
      read_rx(d, pe, fe);
      chk("R5 next frame intact", d, 8'h3C);

      // R10 escape run
      esc_seen = 0;
      send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
      send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
      send_frame(8'h41, 1'b0, 1'b0, 1'b0);
      send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
      send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
      chk("R10 broken run no pulse", esc_seen, 0);
      send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
      chk("R10 third in a row pulses once", esc_seen, 1);
      while (!rx_empty) read_rx(d, pe, fe);

      // R9 CTS holds the transmitter
      cts = 1'b0;
      tx_write(8'h33);
      gap = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!txd) gap++;
      end
      chk("R9 line held high", gap, 0);
      cts = 1'b1;
      tx_capture(d, pb, s1, s2, found);
      chk("R9 char after cts", d, 8'h33);

      // R7 transmit queue full and drop
      cts = 1'b0;
      repeat (20) @(negedge clk);
      for (int i = 0; i < 32; i++) tx_write(8'(i + 8'h40));
      chk("R7 tx_full at 32", tx_full, 1'b1);
      tx_write(8'hEE);
      cts = 1'b1;
      gap = 0;
      for (int i = 0; i < 32; i++) begin
         tx_capture(d, pb, s1, s2, found);
         if (d != 8'(i + 8'h40)) gap++;
      end
      chk("R7 tx order", gap, 0);
      tx_capture(d, pb, s1, s2, found);
      chk("R7 dropped write not sent", found, 1'b0);

      // R8 RTS threshold and R7 receive drop
      for (int i = 0; i < 27; i++) send_frame(8'(i + 8'h10), 1'b0, 1'b0, 1'b0);
      chk("R8 rts high at 27", rts, 1'b1);
      send_frame(8'h2A, 1'b0, 1'b0, 1'b0);
      chk("R8 rts low at 28", rts, 1'b0);
      read_rx(d, pe, fe);
      repeat (2) @(negedge clk);
      chk("R8 rts high again at 27", rts, 1'b1);
      for (int i = 0; i < 5; i++) send_frame(8'(i + 8'h70), 1'b0, 1'b0, 1'b0);
      send_frame(8'hDD, 1'b0, 1'b0, 1'b0);
      gap = 0;
      for (int i = 0; i < 32; i++) read_rx(d, pe, fe);
      chk("R7 last kept entry", d, 8'h74);
      chk("R7 rx overflow dropped", rx_empty, 1'b1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule